// File: doc/BRIEF.md
# Switchable 12/24-hour hours counter

This block is the hours stage of a real-time clock. It holds the current hour in packed BCD and steps it once for every carry pulse that comes from the minutes stage. In 24-hour format it counts 00 to 23 and then wraps. In 12-hour format it counts 12, 1, 2 up to 11. The PM flag sits in bit 7 and changes on each 11 to 12 step. When the day ends (23 to 00, or 11 PM to 12 AM) the block gives a one-cycle day carry for the next stage.

The format is a control bit held inside the block. Initialisation clears it, so the block starts in 24-hour format. When the format bit is written with a new value, the stored hour is re-encoded in place into the other format, so the time of day is unchanged. Software can load the hour directly through a write port. It reads the hour back from a read port.

Top module: `hour_keeper`

## Requirements
- R1: After reset, rd_data is 8'h00 (00 hours), fmt_12h is 0 (24-hour format) and day_carry is 0.
- R2: In 24-hour format (fmt_12h=0), each clock with inc=1 and wr_en=0 steps rd_data in BCD through 8'h00..8'h23. The step from 8'h23 goes to 8'h00, and day_carry is 1 in the following cycle only.
- R3: In 12-hour format, bits 5:0 hold the hour as BCD 1..12 and bit 7 is PM (1=PM). The count runs 12,1,...,11. Bit 7 toggles on the 11 to 12 step. The step from 11 PM (8'h91) to 12 AM (8'h12) gives day_carry.
- R4: Whenever fmt_12h is 0, rd_data bit 7 is 0. A 24-hour write of a value with bit 7 set stores it with bit 7 cleared.
- R5: Writing ctl_fmt12=1 through ctl_wr while in 24-hour format re-encodes the hour into 12-hour format. For example, 00 becomes 8'h12 (12 AM), 12 becomes 8'h92, and 13 becomes 8'h81.
- R6: Writing ctl_fmt12=0 while in 12-hour format re-encodes the hour into 24-hour format. 12 AM becomes 8'h00, 12 PM becomes 8'h12, and 1 PM becomes 8'h13.
- R7: wr_en=1 loads wr_data (a valid hour for the format in force after that cycle) in the next cycle. The write takes priority over inc, and that inc gives no day_carry.
- R8: When inc and a format change come in the same cycle, the hour is first stepped in the old format and then converted. Any day carry from that step is still issued.
- R9: When wr_en and a format change come in the same cycle, wr_data is taken in the new format and is not converted.
- R10: With inc=0, wr_en=0 and no change of format (including ctl_wr rewriting the same value), rd_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous initialisation |
| inc | input | 1 | Carry pulse from the minutes stage |
| wr_en | input | 1 | Load the hours register |
| wr_data | input | 8 | Value to load |
| ctl_wr | input | 1 | Write the format control bit |
| ctl_fmt12 | input | 1 | New format bit: 1 = 12-hour, 0 = 24-hour |
| rd_data | output | 8 | Current hours register |
| fmt_12h | output | 1 | Current format bit |
| day_carry | output | 1 | One-cycle pulse at the end of the day |

## Verification
A minutes carry can arrive in the same cycle as a format change, and a register write can arrive in the same cycle as either of them. Directed cases send a carry at 23:00 together with a switch to 12-hour format, and a write of a PM hour together with a switch to 24-hour format. Random traffic then sets inc, wr_en and ctl_wr independently in every cycle. Every cycle is judged against a bench model that keeps the hour as plain 0..23 and re-encodes it for the present format, so a wrong order of step and conversion shows up as a wrong hour or a missing carry.

// File: rtl/hk_pkg.sv
package hk_pkg;
  localparam int HR_W   = 8;
  localparam int BCD_W  = 6;
  localparam int BIN_W  = 5;
  localparam int PM_BIT = HR_W - 1;

  function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BCD_W-1:0] b);
    return BIN_W'(b[5:4]) * BIN_W'(10) + BIN_W'(b[3:0]);
  endfunction

  function automatic logic [BCD_W-1:0] bin_to_bcd(input logic [BIN_W-1:0] v);
    logic [1:0] tens;
    tens = (v >= BIN_W'(20)) ? 2'd2 : (v >= BIN_W'(10)) ? 2'd1 : 2'd0;
    return {tens, 4'(v - BIN_W'(tens) * BIN_W'(10))};
  endfunction

  // Register image to hour of day 0..23.
  function automatic logic [BIN_W-1:0] hour_of_day(input logic [HR_W-1:0] r, input logic m12);
    logic [BIN_W-1:0] h;
    h = bcd_to_bin(r[BCD_W-1:0]);
    if (!m12) return h;
    if (h == BIN_W'(12)) return r[PM_BIT] ? BIN_W'(12) : BIN_W'(0);
    return r[PM_BIT] ? h + BIN_W'(12) : h;
  endfunction

  // Hour of day 0..23 to register image.
  function automatic logic [HR_W-1:0] hour_image(input logic [BIN_W-1:0] d, input logic m12);
    logic [BIN_W-1:0] h;
    logic             pm;
    if (!m12) return {2'b00, bin_to_bcd(d)};
    pm = (d >= BIN_W'(12));
    h  = pm ? d - BIN_W'(12) : d;
    if (h == '0) h = BIN_W'(12);
    return {pm, 1'b0, bin_to_bcd(h)};
  endfunction
endpackage

// File: rtl/hk_incr.sv
module hk_incr
  import hk_pkg::*;
(
  input  logic [HR_W-1:0] cur,
  input  logic            m12,
  output logic [HR_W-1:0] nxt,
  output logic            wrap
);
  logic [BCD_W-1:0] low;
  logic             pm;

  assign low = cur[BCD_W-1:0];
  assign pm  = cur[PM_BIT];

  always_comb begin
    wrap = 1'b0;
    nxt  = cur;
    if (!m12) begin
      if (low == 6'h23) begin
        nxt  = '0;
        wrap = 1'b1;
      end else if (low[3:0] == 4'd9) begin
        nxt = {2'b00, low[5:4] + 2'd1, 4'd0};
      end else begin
        nxt = {2'b00, low[5:4], low[3:0] + 4'd1};
      end
    end else begin
      if (low == 6'h12) begin
        nxt = {pm, 1'b0, 6'h01};
      end else if (low == 6'h11) begin
        nxt  = {~pm, 1'b0, 6'h12};
        wrap = pm;
      end else if (low[3:0] == 4'd9) begin
        nxt = {pm, 1'b0, 6'h10};
      end else begin
        nxt = {pm, 1'b0, low[5:4], low[3:0] + 4'd1};
      end
    end
  end
endmodule

// File: rtl/hk_convert.sv
module hk_convert
  import hk_pkg::*;
(
  input  logic [HR_W-1:0] cur,
  input  logic            from12,
  input  logic            to12,
  output logic [HR_W-1:0] nxt
);
  always_comb begin
    if (from12 == to12) nxt = cur;
    else                nxt = hour_image(hour_of_day(cur, from12), to12);
  end
endmodule

// File: rtl/hour_keeper.sv
module hour_keeper
  import hk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            wr_en,
  input  logic [HR_W-1:0] wr_data,
  input  logic            ctl_wr,
  input  logic            ctl_fmt12,
  output logic [HR_W-1:0] rd_data,
  output logic            fmt_12h,
  output logic            day_carry
);
  logic            fmt_q, carry_q;
  logic [HR_W-1:0] hr_q;
  logic            fmt_next, fmt_flip, inc_wrap;
  logic [HR_W-1:0] inc_val, stepped, conv_val, load_val;

  assign fmt_next = ctl_wr ? ctl_fmt12 : fmt_q;
  assign fmt_flip = fmt_next != fmt_q;

  hk_incr u_incr (.cur(hr_q), .m12(fmt_q), .nxt(inc_val), .wrap(inc_wrap));

  assign stepped = inc ? inc_val : hr_q;

  hk_convert u_conv (.cur(stepped), .from12(fmt_q), .to12(fmt_next), .nxt(conv_val));

  assign load_val = fmt_next ? wr_data : {1'b0, wr_data[HR_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q   <= 1'b0;
      hr_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      fmt_q   <= fmt_next;
      hr_q    <= wr_en ? load_val : conv_val;
      carry_q <= inc && !wr_en && inc_wrap;
    end
  end

  assign rd_data   = hr_q;
  assign fmt_12h   = fmt_q;
  assign day_carry = carry_q;
endmodule

// File: rtl/hk_checker.sv
module hk_checker
  import hk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            inc,
  input logic            wr_en,
  input logic [HR_W-1:0] wr_data,
  input logic            ctl_wr,
  input logic            ctl_fmt12,
  input logic [HR_W-1:0] rd_data,
  input logic            fmt_12h,
  input logic            day_carry,
  input logic            fmt_flip,
  input logic            inc_wrap
);
  assert_pm_clear_24h_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_12h |-> !rd_data[PM_BIT]);

  assert_carry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> $past(inc && !wr_en && inc_wrap));

  assert_hour_nonzero_12h_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_12h |-> rd_data[BCD_W-1:0] != '0);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en && !(ctl_wr && ctl_fmt12 != fmt_12h)) |=> $stable(rd_data));

  assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fmt_flip) |=> rd_data[HR_W-2:0] == $past(wr_data[HR_W-2:0]));

  assert_flip_follows_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_flip |=> fmt_12h == $past(ctl_fmt12));
endmodule

bind hour_keeper hk_checker u_hk_checker (
  .clk(clk), .rst_n(rst_n), .inc(inc), .wr_en(wr_en), .wr_data(wr_data),
  .ctl_wr(ctl_wr), .ctl_fmt12(ctl_fmt12), .rd_data(rd_data), .fmt_12h(fmt_12h),
  .day_carry(day_carry), .fmt_flip(fmt_flip), .inc_wrap(inc_wrap)
);

// File: tb/tb_hour_keeper.sv
`timescale 1ns/1ps
module tb_hour_keeper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc = 1'b0, wr_en = 1'b0, ctl_wr = 1'b0, ctl_fmt12 = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       fmt_12h, day_carry;

  int checks = 0;
  int fails  = 0;
  int hod;          // model hour of day 0..23
  bit m12;          // model format
  bit exp_carry;
  bit done = 0;

  always #2.5 clk = ~clk;

  hour_keeper dut (.clk(clk), .rst_n(rst_n), .inc(inc), .wr_en(wr_en), .wr_data(wr_data),
                   .ctl_wr(ctl_wr), .ctl_fmt12(ctl_fmt12), .rd_data(rd_data),
                   .fmt_12h(fmt_12h), .day_carry(day_carry));

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic logic [7:0] model_image(int d, bit twelve);
    int h;
    if (!twelve) return to_bcd(d);
    h = ((d + 11) % 12) + 1;
    return to_bcd(h) | ((d / 12) != 0 ? 8'h80 : 8'h00);
  endfunction

  function automatic int model_decode(logic [7:0] r, bit twelve);
    int h;
    h = int'(r[5:4]) * 10 + int'(r[3:0]);
    if (!twelve) return h;
    return (h % 12) + (r[7] ? 12 : 0);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update model, sample after the edge and compare.
  task automatic step(input string tag, input bit i, input bit w, input logic [7:0] d,
                      input bit cw, input bit cf);
    bit newm;
    @(negedge clk);
    inc = i; wr_en = w; wr_data = d; ctl_wr = cw; ctl_fmt12 = cf;
    newm = cw ? cf : m12;
    exp_carry = 0;
    if (w) hod = model_decode(d, newm);
    else if (i) begin
      exp_carry = (hod == 23);
      hod = (hod + 1) % 24;
    end
    m12 = newm;
    @(posedge clk);
    #1;
    inc = 0; wr_en = 0; ctl_wr = 0;
    check(tag, rd_data, model_image(hod, m12));
    check(tag, {7'd0, day_carry}, {7'd0, exp_carry});
    check(tag, {7'd0, fmt_12h}, {7'd0, m12});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    #1;
    check("R1", rd_data, 8'h00);
    check("R1", {7'd0, fmt_12h}, 8'h00);
    check("R1", {7'd0, day_carry}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    hod = 0; m12 = 0;

    // 24-hour counting and wrap
    step("R7", 0, 1, 8'h22, 0, 0);
    step("R2", 1, 0, 8'h00, 0, 0);  check("R2", rd_data, 8'h23);
    step("R2", 1, 0, 8'h00, 0, 0);  check("R2", rd_data, 8'h00); check("R2", {7'd0, day_carry}, 8'h01);
    step("R2", 0, 0, 8'h00, 0, 0);  check("R2", {7'd0, day_carry}, 8'h00);
    step("R2", 1, 0, 8'h09, 1, 0);
    repeat (9) step("R2", 1, 0, 8'h00, 0, 0);
    check("R2", rd_data, 8'h10);

    // 24 -> 12 conversion
    step("R7", 0, 1, 8'h00, 0, 0);
    step("R5", 0, 0, 8'h00, 1, 1);  check("R5", rd_data, 8'h12);
    step("R6", 0, 0, 8'h00, 1, 0);  check("R6", rd_data, 8'h00);
    step("R7", 0, 1, 8'h13, 0, 0);
    step("R5", 0, 0, 8'h00, 1, 1);  check("R5", rd_data, 8'h81);
    step("R6", 0, 0, 8'h00, 1, 0);  check("R6", rd_data, 8'h13);
    step("R7", 0, 1, 8'h12, 0, 0);
    step("R5", 0, 0, 8'h00, 1, 1);  check("R5", rd_data, 8'h92);
    step("R6", 0, 0, 8'h00, 1, 0);  check("R6", rd_data, 8'h12);

    // 12-hour counting
    step("R5", 0, 0, 8'h00, 1, 1);
    step("R7", 0, 1, 8'h11, 0, 0);
    step("R3", 1, 0, 8'h00, 0, 0);  check("R3", rd_data, 8'h92); check("R3", {7'd0, day_carry}, 8'h00);
    step("R3", 1, 0, 8'h00, 0, 0);  check("R3", rd_data, 8'h81);
    step("R7", 0, 1, 8'h91, 0, 0);
    step("R3", 1, 0, 8'h00, 0, 0);  check("R3", rd_data, 8'h12); check("R3", {7'd0, day_carry}, 8'h01);
    step("R3", 1, 0, 8'h00, 0, 0);  check("R3", rd_data, 8'h01);
    step("R7", 1, 1, 8'h91, 0, 0);  check("R7", rd_data, 8'h91); check("R7", {7'd0, day_carry}, 8'h00);

    // Hold, including rewrite of the same format
    step("R10", 0, 0, 8'h00, 1, 1); check("R10", rd_data, 8'h91);
    step("R10", 0, 0, 8'h00, 0, 0); check("R10", rd_data, 8'h91);

    // Same-cycle cases
    step("R6", 0, 0, 8'h00, 1, 0);
    step("R7", 0, 1, 8'h23, 0, 0);
    step("R8", 1, 0, 8'h00, 1, 1);  check("R8", rd_data, 8'h12); check("R8", {7'd0, day_carry}, 8'h01);
    step("R8", 1, 0, 8'h00, 1, 0);  check("R8", rd_data, 8'h01);
    step("R5", 0, 0, 8'h00, 1, 1);
    step("R9", 0, 1, 8'h85, 1, 0);  check("R9", rd_data, 8'h05);
    step("R9", 0, 1, 8'h85, 1, 1);  check("R9", rd_data, 8'h85);
    step("R6", 0, 0, 8'h00, 1, 0);
    step("R4", 0, 1, 8'h87, 0, 0);  check("R4", rd_data, 8'h07);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit ri, rw, rc, rf;
      int v;
      bit pm;
      logic [7:0] d;
      ri = ($urandom % 4) != 0;
      rw = ($urandom % 16) == 0;
      rc = ($urandom % 12) == 0;
      rf = $urandom % 2;
      v  = $urandom % 24;
      d  = model_image(v, rc ? rf : m12);
      pm = $urandom % 2;
      if (!(rc ? rf : m12)) d[7] = pm;  // R4: bit 7 must be dropped in 24-hour format
      step(m12 ? "R3" : "R2", ri, rw, d, rc, rf);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule